// File: doc/BRIEF.md
# Synchronous Channel Serial Port

This block joins a byte-wide transmit queue and a byte-wide receive queue to a clocked synchronous serial line. The serial data clock, the two window enables, the clock-mode select and the serial input all arrive without a fixed phase relationship to the system clock. Each one passes through a two-stage synchronizer, and an edge detector then turns the data clock into rise and fall strobes. The transmit state machine has three states. `TX_IDLE` leaves the line released. `TX_SHIFT` drives the current bit and moves to the next bit on the launch edge. `TX_HOLD` drives a constant one once the eight-bit cap has been reached. The transitions are: open window (IDLE to SHIFT), window closed (any state to IDLE), byte finished with mode high (SHIFT to HOLD), and byte finished with mode low (SHIFT back to SHIFT with a reload).

The receive state machine has two states. `RX_HUNT` slides every sampled bit through an eight-bit window until it sees the flag pattern 0x7E (hunt to data on flag match). `RX_DATA` collects bytes on fixed eight-bit boundaries that start right after the flag and offers each byte to the receive queue. No transition leaves `RX_DATA` except reset. The queues themselves are outside this block. The transmit side is a valid/ready pop port and the receive side is a one-cycle push port with a not-full input.

Top module: `sync_chan_port`

## Requirements
- R1: `sdo_en` is low and `sdo` is high impedance whenever `rst_n` is low or the output enable has been low for more than a few system clocks. While the window is open, the line is driven.
- R2: With `cmode` low, the line presents the MSB of the loaded byte when the window opens and advances one bit on each falling edge of `dclk`. Rising edges do not move it. After eight falling edges the next byte follows with no gap.
- R3: With `cmode` high, the line advances one bit only on each rising edge of `dclk`. Falling edges do not move it.
- R4: With `cmode` high, at most eight bits go out per window. From the eighth rising edge until the window closes, the line is driven high.
- R5: A byte is popped (`tx_valid` and `tx_ready` both high for one cycle) when a window opens. With `cmode` low, another byte is also popped after every eighth launch edge. When the queue is empty, 0xFF is sent and nothing is popped.
- R6: `sdi` is sampled on falling edges of `dclk` only while `ie` is high. Clock edges with `ie` low change neither the data nor the bit alignment.
- R7: After reset, no byte is pushed and `rx_synced` stays low until the eight most recent sampled bits equal 0x7E (first bit received = MSB). `rx_synced` then goes high.
- R8: The flag byte that ends the lockout is not pushed. Byte boundaries start with the first bit sampled after it, MSB first.
- R9: A completed byte is pushed (`rx_valid` pulse with `rx_data`) only if `rx_ready` was high. Otherwise the byte is dropped and `rx_overrun` goes high and stays high until reset.
- R10: Reset clears `rx_synced` and `rx_overrun`, releases the line and restores the lockout of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Serial data clock (asynchronous) |
| oe | input | 1 | Output window enable |
| cmode | input | 1 | Clock mode: 0 falling-edge launch, 1 rising-edge launch with 8-bit cap |
| ie | input | 1 | Input window enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Three-state serial data output |
| sdo_en | output | 1 | High while sdo is driven |
| tx_data | input | 8 | Byte at the head of the transmit queue |
| tx_valid | input | 1 | Transmit queue not empty |
| tx_ready | output | 1 | Pop strobe for the transmit queue |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Push strobe for the receive queue |
| rx_ready | input | 1 | Receive queue not full |
| rx_synced | output | 1 | Flag seen since reset |
| rx_overrun | output | 1 | Sticky: a byte was dropped because the queue was full |

## Verification
The transmit side runs long windows in mode 0 across several random queued bytes, short capped windows in mode 1, and windows with an empty queue. The bench samples just before each launch edge, so a design that launched on the wrong edge would show a one-bit skew, and a design without the cap would show data instead of ones after the eighth bit. The receive side first sends bytes that contain no flag, to separate hunting from storing. It then sends the flag and random bytes, to test alignment and that the flag is not stored. Clock bursts with `ie` low test that disabled edges are ignored, and a closed receive queue tests the drop and the sticky overrun. A reset in the middle of a run shows that the lockout comes back.

// File: rtl/scif_pkg.sv
package scif_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FLAG_WORD = 8'h7E;

    localparam int CH_DCLK = 0;
    localparam int CH_OE   = 1;
    localparam int CH_IE   = 2;
    localparam int CH_SDI  = 3;
    localparam int CH_CM   = 4;
    localparam int N_CH    = 5;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_HOLD  = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_HUNT = 1'b0,
        RX_DATA = 1'b1
    } rx_state_e;
endpackage

// File: rtl/scif_sync.sv
module scif_sync #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl
);
    for (genvar c = 0; c < N; c++) begin : g_ch
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '0;
            end else begin
                pipe <= {pipe[STAGES-2:0], raw[c]};
            end
        end
        assign lvl[c] = pipe[STAGES-1];
    end
endmodule

// File: rtl/scif_edge.sv
module scif_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl;
        end
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/scif_tx.sv
module scif_tx
    import scif_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_lvl,
    input  logic         cmode,
    input  logic         launch,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    output logic         tx_ready,
    output logic         out_bit,
    output logic         drive
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    tx_state_e     state, state_d;
    logic [W-1:0]  shreg;
    logic [CW-1:0] cnt;
    logic          oe_q;
    logic          oe_rise;
    logic          byte_end;
    logic          load;

    assign oe_rise  = oe_lvl & ~oe_q;
    assign byte_end = launch && (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            TX_IDLE: begin
                if (oe_rise) state_d = TX_SHIFT;
            end
            TX_SHIFT: begin
                if (!oe_lvl)                state_d = TX_IDLE;
                else if (byte_end && cmode) state_d = TX_HOLD;
                else                        state_d = TX_SHIFT;
            end
            TX_HOLD: begin
                if (!oe_lvl) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load    = 1'b0;
        out_bit = shreg[W-1];
        drive   = 1'b0;
        unique case (state)
            TX_IDLE: begin
                load = oe_rise;
            end
            TX_SHIFT: begin
                drive = 1'b1;
                load  = oe_lvl && byte_end && !cmode;
            end
            TX_HOLD: begin
                drive   = 1'b1;
                out_bit = 1'b1;
            end
            default: ;
        endcase
    end

    assign tx_ready = load;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '1;
            cnt   <= '0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= oe_lvl;
            if (load) begin
                shreg <= tx_valid ? tx_data : '1;
                cnt   <= '0;
            end else if (state == TX_SHIFT && launch) begin
                shreg <= {shreg[W-2:0], 1'b1};
                cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end
    end

    // R1: a closed window releases the line on the next cycle
    a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_lvl |=> !drive);
    // R2: between launch edges the presented bit holds
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SHIFT && !launch) |=> $stable(out_bit));
    // R4: in capped mode a pop only happens when a window opens
    a_r4_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && cmode) |-> oe_rise);
    // R5: pops only inside an open window
    a_r5_pop_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> oe_lvl);
endmodule

// File: rtl/scif_rx.sv
module scif_rx
    import scif_pkg::*;
#(
    parameter int W = BYTE_W,
    parameter logic [W-1:0] FLAG = FLAG_WORD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         sdi,
    input  logic         rx_ready,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    output logic         synced,
    output logic         overrun
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    rx_state_e     state, state_d;
    logic [W-1:0]  sh, sh_next;
    logic [CW-1:0] cnt;
    logic          flag_hit;
    logic          push;

    assign sh_next  = {sh[W-2:0], sdi};
    assign flag_hit = (sh_next == FLAG);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_HUNT;
        end else begin
            state <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            RX_HUNT: if (sample && flag_hit) state_d = RX_DATA;
            RX_DATA: state_d = RX_DATA;
            default: state_d = RX_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        push   = 1'b0;
        synced = 1'b0;
        unique case (state)
            RX_HUNT: ;
            RX_DATA: begin
                synced = 1'b1;
                push   = sample && (cnt == LAST);
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '1;
            cnt      <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            rx_valid <= push && rx_ready;
            if (push) rx_data <= sh_next;
            if (push && !rx_ready) overrun <= 1'b1;
            if (sample) begin
                sh <= sh_next;
                if (state == RX_DATA) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                else                  cnt <= '0;
            end
        end
    end

    // R7: nothing is stored while hunting for the flag
    a_r7_no_push_hunting: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HUNT) |=> !rx_valid);
    // R9: a push implies the queue had room
    a_r9_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_ready));
    // R9: overrun is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R6: without a sample strobe the alignment does not move
    a_r6_idle_alignment: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(cnt) && $stable(sh));
endmodule

// File: rtl/sync_chan_port.sv
module sync_chan_port
    import scif_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int W           = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dclk,
    input  logic         oe,
    input  logic         cmode,
    input  logic         ie,
    input  logic         sdi,
    output logic         sdo,
    output logic         sdo_en,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    output logic         tx_ready,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    input  logic         rx_ready,
    output logic         rx_synced,
    output logic         rx_overrun
);
    logic [N_CH-1:0] raw, lvl;
    logic dclk_rise, dclk_fall;
    logic launch, out_bit, drive;

    always_comb begin
        raw          = '0;
        raw[CH_DCLK] = dclk;
        raw[CH_OE]   = oe;
        raw[CH_IE]   = ie;
        raw[CH_SDI]  = sdi;
        raw[CH_CM]   = cmode;
    end

    scif_sync #(.N(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw), .lvl(lvl)
    );

    scif_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl[CH_DCLK]),
        .rise(dclk_rise), .fall(dclk_fall)
    );

    assign launch = lvl[CH_CM] ? dclk_rise : dclk_fall;

    scif_tx #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .oe_lvl(lvl[CH_OE]), .cmode(lvl[CH_CM]),
        .launch(launch), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .out_bit(out_bit), .drive(drive)
    );

    scif_rx #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sample(dclk_fall && lvl[CH_IE]),
        .sdi(lvl[CH_SDI]), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .synced(rx_synced), .overrun(rx_overrun)
    );

    assign sdo_en = drive && rst_n;
    assign sdo    = sdo_en ? out_bit : 1'bz;
endmodule

// File: tb/sync_chan_port_tb_top.sv
module sync_chan_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dclk = 1'b0, oe = 1'b0, cmode = 1'b0, ie = 1'b0, sdi = 1'b0;
    wire  sdo;
    logic sdo_en;
    logic [7:0] tx_data;
    logic tx_valid, tx_ready;
    logic [7:0] rx_data;
    logic rx_valid, rx_synced, rx_overrun;
    logic rx_ready = 1'b1;

    int errors = 0;
    int checks = 0;

    logic [7:0] txq [64];
    int txh = 0, txn = 0;
    logic [7:0] got [64];
    int gotn = 0;
    logic [7:0] expq [64];
    int expn = 0;

    always #2 clk = ~clk;

    assign tx_valid = (txh < txn);
    assign tx_data  = txq[txh];

    always @(posedge clk) begin
        if (tx_valid && tx_ready) txh <= txh + 1;
        if (rx_valid && gotn < 64) begin
            got[gotn] <= rx_data;
            gotn <= gotn + 1;
        end
    end

    sync_chan_port dut_i (
        .clk(clk), .rst_n(rst_n), .dclk(dclk), .oe(oe), .cmode(cmode),
        .ie(ie), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_synced(rx_synced), .rx_overrun(rx_overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit tx_exp(input bit cm, input int k, input int h);
        logic [7:0] b;
        int j = cm ? 0 : k / 8;
        if (cm && k >= 8) return 1'b1;
        b = (h + j < txn) ? txq[h + j] : 8'hFF;
        return b[7 - (k % 8)];
    endfunction

    task automatic tx_window(input bit cm, input int n, input string req);
        int h0, loads, pops;
        cmode = cm; oe = 1'b0;
        wclk(10);
        h0 = txh;
        oe = 1'b1;
        wclk(20);
        chk(sdo_en == 1'b1, "R1", sdo_en, 1);
        for (int k = 0; k < n; k++) begin
            if (!cm) begin
                dclk = 1'b1; wclk(20);
                chk(sdo == tx_exp(cm, k, h0), req, sdo, tx_exp(cm, k, h0));
                dclk = 1'b0; wclk(20);
            end else begin
                chk(sdo == tx_exp(cm, k, h0), req, sdo, tx_exp(cm, k, h0));
                dclk = 1'b1; wclk(20);
                dclk = 1'b0; wclk(20);
            end
        end
        chk(sdo == tx_exp(cm, n, h0), cm ? "R4" : "R2", sdo, tx_exp(cm, n, h0));
        loads = cm ? 1 : 1 + n / 8;
        pops  = (txn - h0 < loads) ? txn - h0 : loads;
        chk(txh - h0 == pops, "R5", txh - h0, pops);
        oe = 1'b0;
        wclk(10);
        chk(sdo_en == 1'b0, "R1", sdo_en, 0);
    endtask

    task automatic rx_bit(input bit b);
        sdi = b;
        dclk = 1'b1; wclk(20);
        dclk = 1'b0; wclk(20);
    endtask

    task automatic rx_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) rx_bit(b[i]);
    endtask

    task automatic cmp_rx(input string req);
        wclk(10);
        chk(gotn == expn, req, gotn, expn);
        for (int i = 0; i < expn && i < gotn; i++)
            chk(got[i] == expq[i], req, got[i], expq[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'h5EED));
        wclk(5);
        // R1 / R10: reset state
        chk(sdo_en == 1'b0, "R1", sdo_en, 0);
        chk(rx_synced == 1'b0, "R10", rx_synced, 0);
        chk(rx_overrun == 1'b0, "R10", rx_overrun, 0);
        rst_n = 1'b1;
        wclk(10);
        chk(tx_ready == 1'b0 && sdo_en == 1'b0, "R1", sdo_en, 0);

        // transmit: mode 0, three random bytes, 24 launches -> R2
        for (int i = 0; i < 3; i++) txq[txn + i] = 8'($urandom);
        txn += 3;
        tx_window(1'b0, 24, "R2");
        // mode 1 capped -> R3 / R4
        txq[txn] = 8'($urandom); txq[txn + 1] = 8'h5A; txn += 2;
        tx_window(1'b1, 12, "R3");
        tx_window(1'b1, 9, "R4");
        // empty queue -> R5 sends ones
        tx_window(1'b0, 10, "R5");
        tx_window(1'b1, 8, "R5");

        // receive: no flag yet -> R7
        ie = 1'b1;
        rx_byte(8'h00); rx_byte(8'hFF); rx_byte(8'h00);
        cmp_rx("R7");
        chk(rx_synced == 1'b0, "R7", rx_synced, 0);
        rx_byte(8'h7E);
        wclk(5);
        chk(rx_synced == 1'b1, "R7", rx_synced, 1);
        cmp_rx("R8");
        for (int i = 0; i < 12; i++) begin
            b = 8'($urandom);
            expq[expn++] = b;
            rx_byte(b);
        end
        cmp_rx("R8");
        // disabled edges ignored -> R6
        ie = 1'b0;
        for (int i = 0; i < 5; i++) rx_bit(1'($urandom));
        ie = 1'b1;
        expq[expn++] = 8'hC3;
        rx_byte(8'hC3);
        cmp_rx("R6");
        // full queue -> R9
        rx_ready = 1'b0;
        rx_byte(8'h99);
        cmp_rx("R9");
        chk(rx_overrun == 1'b1, "R9", rx_overrun, 1);
        rx_ready = 1'b1;
        expq[expn++] = 8'h3C;
        rx_byte(8'h3C);
        cmp_rx("R9");
        chk(rx_overrun == 1'b1, "R9", rx_overrun, 1);

        // reset restores lockout -> R10
        rst_n = 1'b0;
        wclk(5);
        chk(rx_overrun == 1'b0 && rx_synced == 1'b0, "R10", rx_overrun, 0);
        rst_n = 1'b1;
        wclk(5);
        rx_byte(8'h12); rx_byte(8'h34);
        cmp_rx("R10");
        chk(rx_synced == 1'b0, "R10", rx_synced, 0);
        rx_byte(8'h7E);
        expq[expn++] = 8'hA5;
        rx_byte(8'hA5);
        cmp_rx("R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule